// File: doc/BRIEF.md
# Dual-Rank DAC Register Core

This block is the digital register core that sits in front of an 18-bit current-output converter with a selectable output range. It holds two ranks of registers, an input rank and an active rank. Each rank has a data word and a span (range) code. A host drives the control pins to load the input rank, to transfer the whole input rank into the active rank in one step, or to read either rank back on the data or span bus. The active data word and the effective span code leave the block and feed the converter model.

The control strobes (write, update, read) are brought into the clock domain through a synchronizer and acted on once per assertion. An asynchronous active-low clear forces both data registers to the code that gives a zero-volt output for the span in use. A strap input locks the span to a value fixed on separate strap pins. While the strap is set, the span registers cannot be written, updated or read back.

Top module: `dac_regcore`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both data registers and both span registers clear to 0 and the strobe synchronizer returns to idle. After reset, `act_code` is 0 and, with the strap low, `act_span` is 0.
- R2: A falling edge on `wr_n` with `rd` low and `sel_span` = 0 loads `d_in` into the input data register. Bit 17 is the MSB. The load happens on the third rising edge after the pin changes (two synchronizer stages plus edge detection). `d_in` and `sel_span` are sampled on that edge.
- R3: The same write with `sel_span` = 1 loads `s_in` into the input span register and leaves the input data register unchanged.
- R4: A `wr_n` falling edge that occurs while `rd` is high changes no register.
- R5: A rising edge on `upd` with `rd` low copies both input registers into their active registers, whatever the level of `sel_span`. Until then, `act_code` and `act_span` keep their previous values.
- R6: Each strobe assertion acts only once. If `upd` is held high, a write made during that time reaches the input rank but not the active rank.
- R7: While `rd` is high, `upd` chooses the rank to read: 0 reads the input register and 1 reads the active register. A rising edge of `upd` while `rd` is high does not update.
- R8: `d_oe` is high exactly when `rd` = 1 and `sel_span` = 0. `s_oe` is high exactly when `rd` = 1, `sel_span` = 1 and `man_span` = 0. A bus whose enable is low reads as all zeros. The two enables are never high together.
- R9: When `clr_n` goes low, both data registers load a clear code at once, without waiting for a clock edge, and hold it while `clr_n` stays low. The span registers are not changed. The code depends on the effective span. Span codes 000 (0..5 V), 001 (0..10 V) and the unused codes 110 and 111 give 18'h00000. Codes 010 (±5 V), 011 (±10 V) and 100 (±2.5 V) give 18'h20000. Code 101 (-2.5..7.5 V) gives 18'h10000.
- R10: While `man_span` = 1, span writes and span updates leave the span registers untouched, span readback is disabled, and `act_span` equals `strap_span`. The clear code is also taken from `strap_span`. Data writes and updates still work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_n | input | 1 | Asynchronous active-low clear to the zero-volt code |
| man_span | input | 1 | Strap: 1 fixes the span to `strap_span` |
| strap_span | input | 3 | Fixed span code used while strapped |
| sel_span | input | 1 | Port select: 0 data, 1 span |
| wr_n | input | 1 | Active-low write strobe |
| upd | input | 1 | Update strobe; rank selector while reading |
| rd | input | 1 | Readback enable |
| d_in | input | 18 | Data bus, host to block |
| s_in | input | 3 | Span bus, host to block |
| d_out | output | 18 | Data readback bus |
| d_oe | output | 1 | Data readback drive enable |
| s_out | output | 3 | Span readback bus |
| s_oe | output | 1 | Span readback drive enable |
| act_code | output | 18 | Active data word to the converter |
| act_span | output | 3 | Effective span code to the converter |

## Verification
The bench builds the block with an 18-bit data word, a 3-bit span code and a two-stage synchronizer. With these values the half-scale and quarter-scale clear codes land on bits 17 and 16, where a wrong shift shows up at once. The short synchronizer also makes the three-edge write and update latency visible in the cycle-by-cycle comparison. All eight span codes are cleared in turn, and the strap mode is covered both with the clear and with blocked span traffic.

// File: rtl/dac_regcore_pkg.sv
// Package dac_regcore_pkg
// Shared types for the DAC register core: the span code values and the
// kind of clear code each span needs for a zero-volt output.
// Assumes a 3-bit span code; codes without a named range behave as 0..5 V.
package dac_regcore_pkg;

    typedef enum logic [2:0] {
        RNG_UNI5   = 3'd0,
        RNG_UNI10  = 3'd1,
        RNG_BIP5   = 3'd2,
        RNG_BIP10  = 3'd3,
        RNG_BIP2P5 = 3'd4,
        RNG_OFFSET = 3'd5
    } range_e;

    typedef enum logic [1:0] {
        CLR_ZERO    = 2'd0,
        CLR_HALF    = 2'd1,
        CLR_QUARTER = 2'd2
    } clr_kind_e;

    // Map a span code to the scale point that gives zero volts.
    function automatic clr_kind_e clear_kind(input logic [2:0] span);
        case (span)
            RNG_BIP5, RNG_BIP10, RNG_BIP2P5: clear_kind = CLR_HALF;
            RNG_OFFSET:                      clear_kind = CLR_QUARTER;
            default:                         clear_kind = CLR_ZERO;
        endcase
    endfunction

endpackage

// File: rtl/dac_strobe_sync.sv
// Module dac_strobe_sync
// Brings the write, update and read pins into the clock domain through
// STAGES flops. It then detects the assertion edge of write and update, so
// each one gives a single-cycle pulse. Pulses are suppressed while the
// synchronized read level is high.
// Assumes the pins are held for at least one clock period and STAGES >= 1.
module dac_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_n,
    input  logic upd,
    input  logic rd,
    output logic wr_pulse,
    output logic upd_pulse
);
    localparam int NSIG    = 3;
    localparam int B_WR    = 0;
    localparam int B_UPD   = 1;
    localparam int B_RD    = 2;

    logic [NSIG-1:0] raw_req;
    logic [NSIG-1:0] stage_q [STAGES];
    logic [NSIG-1:0] prev_q;
    logic [NSIG-1:0] rise;

    // Pins as active-high requests, all zero when idle.
    assign raw_req = {rd, upd, ~wr_n};

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First synchronizer flop captures the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[i] <= '0;
                else        stage_q[i] <= raw_req;
            end
        end else begin : g_next
            // Later flops pass the previous stage on.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[i] <= '0;
                else        stage_q[i] <= stage_q[i-1];
            end
        end
    end

    // Last synchronized value, one cycle older, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= stage_q[STAGES-1];
    end

    assign rise      = stage_q[STAGES-1] & ~prev_q;
    assign wr_pulse  = rise[B_WR]  & ~stage_q[STAGES-1][B_RD];
    assign upd_pulse = rise[B_UPD] & ~stage_q[STAGES-1][B_RD];

endmodule

// File: rtl/dac_span_rank.sv
// Module dac_span_rank
// Input and active span registers. A write pulse loads the span bus into
// the input register. An update pulse moves the input register into the
// active register. While `lock` is high neither register changes.
// Assumes the pulses are already synchronized and one cycle wide.
module dac_span_rank #(
    parameter int SPAN_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock,
    input  logic              wr_en,
    input  logic              upd_en,
    input  logic [SPAN_W-1:0] span_in,
    output logic [SPAN_W-1:0] in_q,
    output logic [SPAN_W-1:0] act_q
);
    // Input span register: loads on a span write.
    always_ff @(posedge clk) begin
        if (!rst_n)               in_q <= '0;
        else if (wr_en && !lock)  in_q <= span_in;
    end

    // Active span register: loads on an update.
    always_ff @(posedge clk) begin
        if (!rst_n)               act_q <= '0;
        else if (upd_en && !lock) act_q <= in_q;
    end

endmodule

// File: rtl/dac_data_rank.sv
// Module dac_data_rank
// Input and active data registers with an asynchronous clear. The clear
// loads both registers with the zero-volt code for the effective span.
// Writes and updates are taken on the clock edge that sees their pulse.
// Assumes DATA_W >= 2 so the half-scale and quarter-scale bits exist.
module dac_data_rank
    import dac_regcore_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int SPAN_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic [SPAN_W-1:0] clr_span,
    input  logic              wr_en,
    input  logic              upd_en,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] in_q,
    output logic [DATA_W-1:0] act_q
);
    localparam logic [DATA_W-1:0] CODE_ZERO    = '0;
    localparam logic [DATA_W-1:0] CODE_HALF    = DATA_W'(1) << (DATA_W - 1);
    localparam logic [DATA_W-1:0] CODE_QUARTER = DATA_W'(1) << (DATA_W - 2);

    logic [DATA_W-1:0] clr_code;

    // Select the zero-volt code for the effective span.
    always_comb begin
        case (clear_kind(3'(clr_span)))
            CLR_HALF:    clr_code = CODE_HALF;
            CLR_QUARTER: clr_code = CODE_QUARTER;
            default:     clr_code = CODE_ZERO;
        endcase
    end

    // Input data register: clear first, then reset, then write.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)      in_q <= clr_code;
        else if (!rst_n) in_q <= '0;
        else if (wr_en)  in_q <= data_in;
    end

    // Active data register: clear first, then reset, then update.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)      act_q <= clr_code;
        else if (!rst_n) act_q <= '0;
        else if (upd_en) act_q <= in_q;
    end

endmodule

// File: rtl/dac_readback.sv
// Module dac_readback
// Readback multiplexer. Drives the data or the span bus, chosen by the
// port select, while read is high. The update pin chooses the input rank
// (0) or the active rank (1). Span readback is disabled while strapped.
// A bus that is not enabled reads as zero.
module dac_readback #(
    parameter int DATA_W = 18,
    parameter int SPAN_W = 3
) (
    input  logic              rd,
    input  logic              rank_sel,
    input  logic              sel_span,
    input  logic              lock,
    input  logic [DATA_W-1:0] data_in_q,
    input  logic [DATA_W-1:0] data_act_q,
    input  logic [SPAN_W-1:0] span_in_q,
    input  logic [SPAN_W-1:0] span_act_q,
    output logic [DATA_W-1:0] d_out,
    output logic              d_oe,
    output logic [SPAN_W-1:0] s_out,
    output logic              s_oe
);
    // Enables follow the read level and the port select.
    always_comb begin
        d_oe = rd && !sel_span;
        s_oe = rd && sel_span && !lock;
    end

    // Rank multiplexers, gated to zero when not enabled.
    always_comb begin
        d_out = '0;
        s_out = '0;
        if (d_oe) d_out = rank_sel ? data_act_q : data_in_q;
        if (s_oe) s_out = rank_sel ? span_act_q : span_in_q;
    end

endmodule

// File: rtl/dac_regcore.sv
// Module dac_regcore
// Top of the DAC register core. It connects the strobe synchronizer, the
// data and span ranks and the readback mux. It routes write pulses by the
// port select and forms the effective span from the strap.
// Assumes `sel_span`, `d_in` and `s_in` are held steady until a strobe has
// taken effect, three clock edges with the default synchronizer.
module dac_regcore #(
    parameter int DATA_W      = 18,
    parameter int SPAN_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              man_span,
    input  logic [SPAN_W-1:0] strap_span,
    input  logic              sel_span,
    input  logic              wr_n,
    input  logic              upd,
    input  logic              rd,
    input  logic [DATA_W-1:0] d_in,
    input  logic [SPAN_W-1:0] s_in,
    output logic [DATA_W-1:0] d_out,
    output logic              d_oe,
    output logic [SPAN_W-1:0] s_out,
    output logic              s_oe,
    output logic [DATA_W-1:0] act_code,
    output logic [SPAN_W-1:0] act_span
);
    logic              wr_pulse;
    logic              upd_pulse;
    logic [DATA_W-1:0] data_in_q;
    logic [DATA_W-1:0] data_act_q;
    logic [SPAN_W-1:0] span_in_q;
    logic [SPAN_W-1:0] span_act_q;
    logic [SPAN_W-1:0] eff_span;

    dac_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_n      (wr_n),
        .upd       (upd),
        .rd        (rd),
        .wr_pulse  (wr_pulse),
        .upd_pulse (upd_pulse)
    );

    dac_data_rank #(.DATA_W(DATA_W), .SPAN_W(SPAN_W)) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_n    (clr_n),
        .clr_span (eff_span),
        .wr_en    (wr_pulse && !sel_span),
        .upd_en   (upd_pulse),
        .data_in  (d_in),
        .in_q     (data_in_q),
        .act_q    (data_act_q)
    );

    dac_span_rank #(.SPAN_W(SPAN_W)) u_span (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock    (man_span),
        .wr_en   (wr_pulse && sel_span),
        .upd_en  (upd_pulse),
        .span_in (s_in),
        .in_q    (span_in_q),
        .act_q   (span_act_q)
    );

    dac_readback #(.DATA_W(DATA_W), .SPAN_W(SPAN_W)) u_rb (
        .rd         (rd),
        .rank_sel   (upd),
        .sel_span   (sel_span),
        .lock       (man_span),
        .data_in_q  (data_in_q),
        .data_act_q (data_act_q),
        .span_in_q  (span_in_q),
        .span_act_q (span_act_q),
        .d_out      (d_out),
        .d_oe       (d_oe),
        .s_out      (s_out),
        .s_oe       (s_oe)
    );

    // Effective span: strap value when strapped, else the active register.
    assign eff_span = man_span ? strap_span : span_act_q;
    assign act_span = eff_span;
    assign act_code = data_act_q;

endmodule

// File: rtl/dac_regcore_chk.sv
// Module dac_regcore_chk
// Property checker for dac_regcore, attached by bind. It watches the
// ports together with the rank registers and the strobe pulses.
module dac_regcore_chk #(
    parameter int DATA_W = 18,
    parameter int SPAN_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_n,
    input logic              man_span,
    input logic              sel_span,
    input logic              upd,
    input logic              rd,
    input logic              d_oe,
    input logic              s_oe,
    input logic [DATA_W-1:0] d_out,
    input logic [DATA_W-1:0] act_code,
    input logic [SPAN_W-1:0] act_span,
    input logic              upd_pulse,
    input logic [DATA_W-1:0] data_in_q,
    input logic [SPAN_W-1:0] span_in_q,
    input logic [SPAN_W-1:0] span_act_q
);
    logic [DATA_W-1:0] exp_clr;

    // Expected zero-volt code, written from the span table.
    always_comb begin
        case (act_span)
            3'd2, 3'd3, 3'd4: exp_clr = DATA_W'(1) << (DATA_W - 1);
            3'd5:             exp_clr = DATA_W'(1) << (DATA_W - 2);
            default:          exp_clr = '0;
        endcase
    end

    assert_oe_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({d_oe, s_oe}));

    assert_oe_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |-> (!d_oe && !s_oe));

    assert_update_copies_R5: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        upd_pulse |=> (act_code == $past(data_in_q)));

    assert_active_holds_R6: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        !upd_pulse |=> $stable(act_code));

    assert_clear_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (act_code == exp_clr));

    assert_strap_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        man_span |=> ($stable(span_in_q) && $stable(span_act_q)));

    assert_readback_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !sel_span && !upd) |-> (d_out == data_in_q));

endmodule

bind dac_regcore dac_regcore_chk #(.DATA_W(DATA_W), .SPAN_W(SPAN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_n      (clr_n),
    .man_span   (man_span),
    .sel_span   (sel_span),
    .upd        (upd),
    .rd         (rd),
    .d_oe       (d_oe),
    .s_oe       (s_oe),
    .d_out      (d_out),
    .act_code   (act_code),
    .act_span   (act_span),
    .upd_pulse  (upd_pulse),
    .data_in_q  (data_in_q),
    .span_in_q  (span_in_q),
    .span_act_q (span_act_q)
);

// File: tb/sim_dac_regcore.sv
// Bench for dac_regcore: a behavioural reference model is compared on
// every clock, and directed checks are made at the requirement boundaries.
module sim_dac_regcore;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 18;
    localparam int SW         = 3;
    localparam int SYNC       = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr_n = 1'b1;
    logic          man_span = 1'b0;
    logic [SW-1:0] strap_span = '0;
    logic          sel_span = 1'b0;
    logic          wr_n = 1'b1;
    logic          upd = 1'b0;
    logic          rd = 1'b0;
    logic [DW-1:0] d_in = '0;
    logic [SW-1:0] s_in = '0;
    logic [DW-1:0] d_out;
    logic          d_oe;
    logic [SW-1:0] s_out;
    logic          s_oe;
    logic [DW-1:0] act_code;
    logic [SW-1:0] act_span;

    int    checks = 0;
    int    errors = 0;
    string phase = "R1";

    // Reference model state.
    logic [DW-1:0] m_din = '0, m_dact = '0;
    logic [SW-1:0] m_sin = '0, m_sact = '0;
    bit h_wr [SYNC+1];
    bit h_upd[SYNC+1];
    bit h_rd [SYNC+1];

    dac_regcore #(.DATA_W(DW), .SPAN_W(SW), .SYNC_STAGES(SYNC)) u0 (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .man_span(man_span),
        .strap_span(strap_span), .sel_span(sel_span), .wr_n(wr_n), .upd(upd),
        .rd(rd), .d_in(d_in), .s_in(s_in), .d_out(d_out), .d_oe(d_oe),
        .s_out(s_out), .s_oe(s_oe), .act_code(act_code), .act_span(act_span)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] zero_volt(input logic [SW-1:0] sp);
        case (sp)
            3'd2, 3'd3, 3'd4: return 18'h20000;
            3'd5:             return 18'h10000;
            default:          return 18'h00000;
        endcase
    endfunction

    function automatic logic [SW-1:0] m_eff_span();
        return man_span ? strap_span : m_sact;
    endfunction

    // Model: requests seen SYNC edges ago, edge against one edge older.
    always @(posedge clk) begin
        if (!rst_n) begin
            if (clr_n) begin m_din = '0; m_dact = '0; end
            m_sin = '0; m_sact = '0;
            for (int i = 0; i <= SYNC; i++) begin h_wr[i] = 0; h_upd[i] = 0; h_rd[i] = 0; end
        end else begin
            bit do_wr, do_upd;
            logic [DW-1:0] old_din;
            logic [SW-1:0] old_sin;
            do_wr  = h_wr[SYNC-1]  && !h_wr[SYNC]  && !h_rd[SYNC-1];
            do_upd = h_upd[SYNC-1] && !h_upd[SYNC] && !h_rd[SYNC-1];
            old_din = m_din; old_sin = m_sin;
            if (!clr_n) begin
                m_din = zero_volt(m_eff_span()); m_dact = m_din;
            end else begin
                if (do_wr && !sel_span) m_din = d_in;
                if (do_upd) m_dact = old_din;
            end
            if (!man_span) begin
                if (do_wr && sel_span) m_sin = s_in;
                if (do_upd) m_sact = old_sin;
            end
            for (int i = SYNC; i > 0; i--) begin
                h_wr[i] = h_wr[i-1]; h_upd[i] = h_upd[i-1]; h_rd[i] = h_rd[i-1];
            end
            h_wr[0] = !wr_n; h_upd[0] = upd; h_rd[0] = rd;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // Every-clock comparison against the model, a quarter period after the edge.
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n) begin
            logic [DW-1:0] e_dout;
            logic [SW-1:0] e_sout;
            logic e_doe, e_soe;
            e_doe  = rd && !sel_span;
            e_soe  = rd && sel_span && !man_span;
            e_dout = e_doe ? (upd ? m_dact : m_din) : '0;
            e_sout = e_soe ? (upd ? m_sact : m_sin) : '0;
            chk(phase, "act_code", 32'(act_code), 32'(m_dact));
            chk(phase, "act_span", 32'(act_span), 32'(m_eff_span()));
            chk(phase, "d_oe",     32'(d_oe),     32'(e_doe));
            chk(phase, "s_oe",     32'(s_oe),     32'(e_soe));
            chk(phase, "d_out",    32'(d_out),    32'(e_dout));
            chk(phase, "s_out",    32'(s_out),    32'(e_sout));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input bit sel, input logic [DW-1:0] d, input logic [SW-1:0] s);
        sel_span = sel; d_in = d; s_in = s;
        wr_n = 1'b0; cyc(2); wr_n = 1'b1; cyc(4);
    endtask

    task automatic do_update(input bit sel);
        sel_span = sel; upd = 1'b1; cyc(2); upd = 1'b0; cyc(4);
    endtask

    task automatic readback(input bit sel, input bit rank,
                            output logic [DW-1:0] dv, output logic [SW-1:0] sv,
                            output logic doe, output logic soe);
        sel_span = sel; rd = 1'b1; cyc(3);
        upd = rank; cyc(1);
        dv = d_out; sv = s_out; doe = d_oe; soe = s_oe;
        upd = 1'b0; cyc(3); rd = 1'b0; cyc(3);
    endtask

    task automatic do_clear();
        clr_n = 1'b0;
        m_din = zero_volt(m_eff_span()); m_dact = m_din;
        cyc(2); clr_n = 1'b1; cyc(1);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [DW-1:0] dv;
        logic [SW-1:0] sv;
        logic doe, soe;
        cyc(4); rst_n = 1'b1; cyc(1);
        chk("R1", "act_code after reset", 32'(act_code), 0);
        chk("R1", "act_span after reset", 32'(act_span), 0);

        phase = "R2";
        do_write(1'b0, 18'h2A5C3, 3'd0);
        readback(1'b0, 1'b0, dv, sv, doe, soe);
        chk("R2", "input data readback", 32'(dv), 32'h2A5C3);
        chk("R8", "d_oe during data read", 32'(doe), 1);
        chk("R8", "s_out idle during data read", 32'(sv), 0);
        chk("R5", "active unchanged before update", 32'(act_code), 0);

        phase = "R3";
        do_write(1'b1, 18'h3FFFF, 3'd3);
        readback(1'b1, 1'b0, dv, sv, doe, soe);
        chk("R3", "input span readback", 32'(sv), 3);
        chk("R8", "s_oe during span read", 32'(soe), 1);
        chk("R8", "d_out idle during span read", 32'(dv), 0);
        readback(1'b0, 1'b0, dv, sv, doe, soe);
        chk("R3", "span write leaves data", 32'(dv), 32'h2A5C3);

        phase = "R5";
        do_update(1'b1);
        chk("R5", "act_code after update", 32'(act_code), 32'h2A5C3);
        chk("R5", "act_span after update", 32'(act_span), 3);

        phase = "R7";
        do_write(1'b0, 18'h00F0F, 3'd0);
        readback(1'b0, 1'b1, dv, sv, doe, soe);
        chk("R7", "active rank readback", 32'(dv), 32'h2A5C3);
        chk("R7", "upd while reading is no update", 32'(act_code), 32'h2A5C3);
        readback(1'b0, 1'b0, dv, sv, doe, soe);
        chk("R7", "input rank readback", 32'(dv), 32'h00F0F);

        phase = "R4";
        sel_span = 1'b0; rd = 1'b1; cyc(3);
        d_in = 18'h15555; wr_n = 1'b0; cyc(2); wr_n = 1'b1; cyc(3);
        rd = 1'b0; cyc(4);
        readback(1'b0, 1'b0, dv, sv, doe, soe);
        chk("R4", "write during read ignored", 32'(dv), 32'h00F0F);

        phase = "R6";
        sel_span = 1'b0; upd = 1'b1; cyc(5);
        do_write(1'b0, 18'h0ABCD, 3'd0);
        chk("R6", "held upd acts once", 32'(act_code), 32'h00F0F);
        upd = 1'b0; cyc(4);
        chk("R6", "release does not update", 32'(act_code), 32'h00F0F);

        phase = "R9";
        for (int sp = 0; sp < 8; sp++) begin
            do_write(1'b1, 18'h0, 3'(sp));
            do_update(1'b0);
            do_write(1'b0, 18'h3C3C3, 3'd0);
            do_update(1'b0);
            clr_n = 1'b0;
            m_din = zero_volt(m_eff_span()); m_dact = m_din;
            #1;
            chk("R9", "clear is immediate", 32'(act_code), 32'(zero_volt(3'(sp))));
            cyc(2); clr_n = 1'b1; cyc(1);
            chk("R9", "clear code held", 32'(act_code), 32'(zero_volt(3'(sp))));
            chk("R9", "span untouched by clear", 32'(act_span), 32'(sp));
            readback(1'b0, 1'b0, dv, sv, doe, soe);
            chk("R9", "input data cleared", 32'(dv), 32'(zero_volt(3'(sp))));
        end

        phase = "R10";
        do_write(1'b1, 18'h0, 3'd1);
        do_update(1'b1);
        man_span = 1'b1; strap_span = 3'd5; cyc(1);
        chk("R10", "act_span from strap", 32'(act_span), 5);
        do_write(1'b1, 18'h0, 3'd4);
        do_update(1'b1);
        readback(1'b1, 1'b0, dv, sv, doe, soe);
        chk("R10", "span readback disabled", 32'(soe), 0);
        chk("R10", "span bus zero when strapped", 32'(sv), 0);
        do_write(1'b0, 18'h12345, 3'd0);
        do_update(1'b0);
        chk("R10", "data update under strap", 32'(act_code), 32'h12345);
        do_clear();
        chk("R10", "clear code from strap", 32'(act_code), 32'h10000);
        man_span = 1'b0; cyc(1);
        chk("R10", "span register kept", 32'(act_span), 1);
        readback(1'b1, 1'b0, dv, sv, doe, soe);
        chk("R10", "input span kept", 32'(sv), 1);

        cyc(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule